// File: doc/BRIEF.md
# Register-Driven SPI Command Engine

This block is a small SPI master that a host controls through an 8-bit register file on a plain synchronous read/write bus. To run a transfer, the host first stores a control byte with its start bit clear. It then loads an opcode and up to three argument bytes, and rewrites the control byte with the start bit set. The engine drives chip select low and shifts out the opcode and the arguments. It then clocks in up to three response bytes and stores them in readable registers. When the transfer is done it clears the start bit.

The start bit also serves as the busy flag. The host polls it until it reads zero and then fetches the response bytes. The SPI side runs in mode 0: the clock idles low, MISO is sampled on the rising edge and MOSI changes on the falling edge. Bytes go most significant bit first. A divider register sets the SPI clock rate.

Top module: `spi_cmd_engine`

## Requirements
- R1: After reset, the control, opcode, argument and response registers read 0, the divider register reads DIV_RESET, chip select is high and SCK is low.
- R2: The opcode (0x61), arguments (0x64, 0x65, 0x66) and divider (0x6C) read back what was written. A control byte written with bit 0 clear reads back unchanged. Unmapped offsets such as 0x62 read 0.
- R3: Writing the control register (0x60) with bit 0 set starts a transfer. Bit 0 reads 1 until the transfer is over and then reads 0, while bits 7:1 keep their value.
- R4: MOSI carries the opcode first, then the argument bytes 0x64, 0x65, 0x66 in that order. Control bits 4:3 give how many arguments are sent (0 to 3). Each byte goes MSB first and is valid at the rising SCK edge.
- R5: Control bits 2:1 give the number of response bytes (0 to 3). These bytes are sampled from MISO on rising SCK edges after the last argument. They land in 0x67, 0x68, 0x69 in arrival order, and MOSI is low while they are received.
- R6: Chip select stays low across the whole sequence, which has exactly 8 x (1 + args + responses) rising SCK edges, and goes high after the last byte. With a response count of zero, the sequence ends right after the last argument.
- R7: SCK is low whenever no byte is being shifted. Each SCK half period lasts (divider + 1) clock cycles.
- R8: A write to the control register while bit 0 is set has no effect, neither on its value nor on the transfer under way.
- R9: Response registers beyond the current response count keep their previous contents.
- R10: Bits 7:5 hold the command class (010 identify/read, 011 status write, 101 erase). The field is stored and read back, and the byte sequence on the bus is the same for every class.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| spi_sck | output | 1 | SPI clock, idle low |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data to the device |
| spi_miso | input | 1 | Serial data from the device |

## Verification
Transfers run with several argument/response mixes: three arguments with three responses, arguments only, opcode with one response, and an erase-class command. The mixes show that the byte counts are decoded from the right fields and that chip select is released at the right byte. The slave model returns a distinct byte for every position, so a response stored in the wrong register, or sampled one byte early or late, is visible. A longer divider exposes SCK half-period errors. It also leaves time to write the control register in mid-transfer, which shows whether the busy lock holds.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
  localparam int unsigned NARG = 3;
  localparam logic [7:0] A_CTRL = 8'h60;
  localparam logic [7:0] A_OPC  = 8'h61;
  localparam logic [7:0] A_ARG0 = 8'h64;
  localparam logic [7:0] A_RSP0 = 8'h67;
  localparam logic [7:0] A_DIV  = 8'h6C;

  typedef struct packed {
    logic [2:0] cls;
    logic [1:0] wcnt;
    logic [1:0] rcnt;
    logic       go;
  } ctrl_t;

  typedef enum logic [1:0] {SQ_IDLE, SQ_LAUNCH, SQ_WAIT, SQ_END} seq_state_t;
endpackage

// File: rtl/spi_cmd_regs.sv
module spi_cmd_regs
  import spi_cmd_pkg::*;
#(
  parameter int unsigned DIV_W     = 8,
  parameter int unsigned DIV_RESET = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_we,
  input  logic [7:0]       bus_addr,
  input  logic [7:0]       bus_wdata,
  output logic [7:0]       bus_rdata,
  output logic [1:0]       wcnt,
  output logic [1:0]       rcnt,
  output logic             go,
  output logic [7:0]       opcode,
  output logic [7:0]       args [NARG],
  output logic [DIV_W-1:0] div,
  input  logic             cap_we,
  input  logic [1:0]       cap_idx,
  input  logic [7:0]       cap_data,
  input  logic             seq_done
);
  ctrl_t            ctrl_q, ctrl_d;
  logic [7:0]       opc_q, opc_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic [7:0]       arg_q [NARG];
  logic [7:0]       rsp_q [NARG];

  always_comb begin
    ctrl_d = ctrl_q;
    if (ctrl_q.go) begin
      if (seq_done) ctrl_d.go = 1'b0;
    end else if (bus_we && bus_addr == A_CTRL) begin
      ctrl_d = ctrl_t'(bus_wdata);
    end
    opc_d = (bus_we && bus_addr == A_OPC) ? bus_wdata : opc_q;
    div_d = (bus_we && bus_addr == A_DIV) ? bus_wdata[DIV_W-1:0] : div_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      opc_q  <= '0;
      div_q  <= DIV_W'(DIV_RESET);
    end else begin
      ctrl_q <= ctrl_d;
      opc_q  <= opc_d;
      div_q  <= div_d;
    end
  end

  for (genvar i = 0; i < NARG; i++) begin : g_slot
    logic [7:0] arg_d, rsp_d;
    always_comb begin
      arg_d = (bus_we && bus_addr == A_ARG0 + 8'(i)) ? bus_wdata : arg_q[i];
      rsp_d = (cap_we && cap_idx == 2'(i)) ? cap_data : rsp_q[i];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        arg_q[i] <= '0;
        rsp_q[i] <= '0;
      end else begin
        arg_q[i] <= arg_d;
        rsp_q[i] <= rsp_d;
      end
    end
    // R9
    rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(cap_we && cap_idx == 2'(i)) |=> $stable(rsp_q[i]));
  end

  always_comb begin
    bus_rdata = 8'h00;
    if (bus_addr == A_CTRL) bus_rdata = ctrl_q;
    if (bus_addr == A_OPC)  bus_rdata = opc_q;
    if (bus_addr == A_DIV)  bus_rdata = 8'(div_q);
    for (int i = 0; i < NARG; i++) begin
      if (bus_addr == A_ARG0 + 8'(i)) bus_rdata = arg_q[i];
      if (bus_addr == A_RSP0 + 8'(i)) bus_rdata = rsp_q[i];
    end
  end

  assign wcnt   = ctrl_q.wcnt;
  assign rcnt   = ctrl_q.rcnt;
  assign go     = ctrl_q.go;
  assign opcode = opc_q;
  assign args   = arg_q;
  assign div    = div_q;

  // R8
  ctrl_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.go && !seq_done) |=> $stable(ctrl_q));
  // R3
  ctrl_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |=> !ctrl_q.go);
endmodule

// File: rtl/spi_cmd_shift.sv
module spi_cmd_shift #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  input  logic             load,
  input  logic [7:0]       tx_byte,
  output logic             busy,
  output logic             done,
  output logic [7:0]       rx_byte,
  output logic             sck,
  output logic             mosi,
  input  logic             miso
);
  logic             busy_q, busy_d, sck_q, sck_d, done_q, done_d;
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic [2:0]       bit_q, bit_d;
  logic [7:0]       sh_q, sh_d, rx_q, rx_d;

  always_comb begin
    busy_d = busy_q;
    sck_d  = sck_q;
    cnt_d  = cnt_q;
    bit_d  = bit_q;
    sh_d   = sh_q;
    rx_d   = rx_q;
    done_d = 1'b0;
    if (!busy_q) begin
      if (load) begin
        busy_d = 1'b1;
        sh_d   = tx_byte;
        cnt_d  = '0;
        bit_d  = '0;
        sck_d  = 1'b0;
      end
    end else if (cnt_q == div) begin
      cnt_d = '0;
      if (!sck_q) begin
        sck_d = 1'b1;
        rx_d  = {rx_q[6:0], miso};
      end else begin
        sck_d = 1'b0;
        if (bit_q == 3'd7) begin
          busy_d = 1'b0;
          done_d = 1'b1;
        end else begin
          bit_d = bit_q + 3'd1;
          sh_d  = {sh_q[6:0], 1'b0};
        end
      end
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sck_q  <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
      bit_q  <= '0;
      sh_q   <= '0;
      rx_q   <= '0;
    end else begin
      busy_q <= busy_d;
      sck_q  <= sck_d;
      done_q <= done_d;
      cnt_q  <= cnt_d;
      bit_q  <= bit_d;
      sh_q   <= sh_d;
      rx_q   <= rx_d;
    end
  end

  assign busy    = busy_q;
  assign done    = done_q;
  assign rx_byte = rx_q;
  assign sck     = sck_q;
  assign mosi    = sh_q[7];

  // R7
  sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> !sck_q);
  // R7
  sck_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cnt_q != div) |=> $stable(sck_q));
endmodule

// File: rtl/spi_cmd_seq.sv
module spi_cmd_seq
  import spi_cmd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] wcnt,
  input  logic [1:0] rcnt,
  input  logic       go,
  input  logic [7:0] opcode,
  input  logic [7:0] args [NARG],
  input  logic       sh_busy,
  input  logic       sh_done,
  input  logic [7:0] sh_rx,
  output logic       load,
  output logic [7:0] tx_byte,
  output logic       cap_we,
  output logic [1:0] cap_idx,
  output logic [7:0] cap_data,
  output logic       seq_done,
  output logic       cs_n
);
  seq_state_t state_q, state_d;
  logic [2:0] idx_q, idx_d;
  logic       cs_n_q, cs_n_d;
  logic [2:0] wc3, last_idx;
  logic [1:0] arg_sel;

  assign wc3      = {1'b0, wcnt};
  assign last_idx = wc3 + {1'b0, rcnt};
  assign arg_sel  = idx_q[1:0] - 2'd1;

  always_comb begin
    if (idx_q == 3'd0)      tx_byte = opcode;
    else if (idx_q <= wc3)  tx_byte = (arg_sel == 2'd0) ? args[0] :
                                      (arg_sel == 2'd1) ? args[1] : args[2];
    else                    tx_byte = 8'h00;
  end

  always_comb begin
    state_d  = state_q;
    idx_d    = idx_q;
    load     = 1'b0;
    cap_we   = 1'b0;
    seq_done = 1'b0;
    cap_idx  = idx_q[1:0] - 2'd1 - wcnt;
    cap_data = sh_rx;
    case (state_q)
      SQ_IDLE: if (go) begin
        state_d = SQ_LAUNCH;
        idx_d   = '0;
      end
      SQ_LAUNCH: begin
        load    = 1'b1;
        state_d = SQ_WAIT;
      end
      SQ_WAIT: if (sh_done) begin
        cap_we = (idx_q > wc3);
        if (idx_q == last_idx) state_d = SQ_END;
        else begin
          idx_d   = idx_q + 3'd1;
          state_d = SQ_LAUNCH;
        end
      end
      default: begin
        seq_done = 1'b1;
        state_d  = SQ_IDLE;
      end
    endcase
    cs_n_d = (state_d == SQ_IDLE) || (state_d == SQ_END);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      idx_q   <= '0;
      cs_n_q  <= 1'b1;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      cs_n_q  <= cs_n_d;
    end
  end

  assign cs_n = cs_n_q;

  // R6
  cs_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sh_busy |-> !cs_n_q);
  // R6
  cs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !go |-> cs_n_q);
  // R3
  load_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !sh_busy);
endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
  import spi_cmd_pkg::*;
#(
  parameter int unsigned DIV_W     = 8,
  parameter int unsigned DIV_RESET = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_we,
  input  logic [7:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       spi_sck,
  output logic       spi_cs_n,
  output logic       spi_mosi,
  input  logic       spi_miso
);
  logic [1:0]       wcnt, rcnt, cap_idx;
  logic             go, cap_we, seq_done, load, sh_busy, sh_done;
  logic [7:0]       opcode, cap_data, tx_byte, sh_rx;
  logic [7:0]       args [NARG];
  logic [DIV_W-1:0] div;

  spi_cmd_regs #(.DIV_W(DIV_W), .DIV_RESET(DIV_RESET)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wcnt(wcnt), .rcnt(rcnt),
    .go(go), .opcode(opcode), .args(args), .div(div), .cap_we(cap_we),
    .cap_idx(cap_idx), .cap_data(cap_data), .seq_done(seq_done)
  );

  spi_cmd_seq u_seq (
    .clk(clk), .rst_n(rst_n), .wcnt(wcnt), .rcnt(rcnt), .go(go),
    .opcode(opcode), .args(args), .sh_busy(sh_busy), .sh_done(sh_done),
    .sh_rx(sh_rx), .load(load), .tx_byte(tx_byte), .cap_we(cap_we),
    .cap_idx(cap_idx), .cap_data(cap_data), .seq_done(seq_done),
    .cs_n(spi_cs_n)
  );

  spi_cmd_shift #(.DIV_W(DIV_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .div(div), .load(load), .tx_byte(tx_byte),
    .busy(sh_busy), .done(sh_done), .rx_byte(sh_rx), .sck(spi_sck),
    .mosi(spi_mosi), .miso(spi_miso)
  );
endmodule

// File: tb/test_spi_cmd_engine.sv
`timescale 1ns/1ps
module test_spi_cmd_engine;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_we = 1'b0;
  logic [7:0] bus_addr = 8'h00;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       spi_sck, spi_cs_n, spi_mosi, spi_miso;

  int total = 0;
  int fails = 0;

  logic [7:0]  slave_bytes [0:7];
  logic        clr = 1'b0;
  logic [7:0]  edges;
  logic [63:0] mosi_log;
  time         t_last = 0, t_prev = 0;

  always #2.5 clk = ~clk;

  spi_cmd_engine i_spi_cmd_engine (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_sck(spi_sck),
    .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  // Slave model: logs MOSI at rising SCK, streams slave_bytes on MISO.
  always @(posedge spi_sck or posedge clr) begin
    if (clr) begin
      edges    <= 8'd0;
      mosi_log <= 64'd0;
    end else begin
      edges    <= edges + 8'd1;
      mosi_log <= {mosi_log[62:0], spi_mosi};
    end
  end
  assign spi_miso = slave_bytes[edges[5:3]][3'd7 - edges[2:0]];

  always @(posedge spi_sck) begin
    t_prev = t_last;
    t_last = $time;
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic clear_slave();
    @(negedge clk);
    clr = 1'b1;
    #1 clr = 1'b0;
  endtask

  task automatic poll_idle();
    logic [7:0] v;
    for (int n = 0; n < 20000; n++) begin
      bus_read(8'h60, v);
      if (!v[0]) return;
    end
    check(1'b0, "R3 poll timeout", 64'(v), 64'h0);
  endtask

  function automatic logic [63:0] exp_stream(input logic [7:0] op,
      input logic [7:0] a0, input logic [7:0] a1, input logic [7:0] a2,
      input int w, input int r);
    logic [63:0] s;
    logic [7:0]  a [3];
    a[0] = a0; a[1] = a1; a[2] = a2;
    s = 64'(op);
    for (int i = 0; i < w; i++) s = (s << 8) | 64'(a[i]);
    for (int i = 0; i < r; i++) s = s << 8;
    return s;
  endfunction

  task automatic load_cmd(input logic [2:0] cls, input int w, input int r,
      input logic [7:0] op, input logic [7:0] a0, input logic [7:0] a1,
      input logic [7:0] a2, output logic [7:0] cb);
    cb = {cls, 2'(w), 2'(r), 1'b0};
    bus_write(8'h60, cb);
    bus_write(8'h61, op);
    bus_write(8'h64, a0);
    bus_write(8'h65, a1);
    bus_write(8'h66, a2);
    clear_slave();
  endtask

  task automatic check_frame(input string tag, input logic [7:0] op,
      input logic [7:0] a0, input logic [7:0] a1, input logic [7:0] a2,
      input int w, input int r);
    int n;
    logic [63:0] mask;
    n = 8 * (1 + w + r);
    mask = (64'd1 << n) - 64'd1;
    check(edges == 8'(n), {tag, " R6 edge count"}, 64'(edges), 64'(n));
    check((mosi_log & mask) == exp_stream(op, a0, a1, a2, w, r),
          {tag, " R4 mosi stream"}, mosi_log & mask, exp_stream(op, a0, a1, a2, w, r));
    check(spi_cs_n == 1'b1, {tag, " R6 cs released"}, 64'(spi_cs_n), 64'd1);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    check(spi_cs_n == 1'b1 && spi_sck == 1'b0, "R1 pins idle",
          64'({spi_cs_n, spi_sck}), 64'h2);
    foreach (slave_bytes[i]) begin end
    for (int a = 8'h60; a <= 8'h69; a++) begin
      bus_read(8'(a), v);
      check(v == 8'h00, "R1 reg zero", 64'(v), 64'h0);
    end
    bus_read(8'h6C, v);
    check(v == 8'h01, "R1 divider reset", 64'(v), 64'h1);
  endtask

  task automatic t_regmap();
    logic [7:0] v;
    bus_write(8'h61, 8'hA5); bus_read(8'h61, v);
    check(v == 8'hA5, "R2 opcode", 64'(v), 64'hA5);
    bus_write(8'h64, 8'h3C); bus_write(8'h65, 8'hC3); bus_write(8'h66, 8'h5A);
    bus_read(8'h64, v); check(v == 8'h3C, "R2 arg0", 64'(v), 64'h3C);
    bus_read(8'h65, v); check(v == 8'hC3, "R2 arg1", 64'(v), 64'hC3);
    bus_read(8'h66, v); check(v == 8'h5A, "R2 arg2", 64'(v), 64'h5A);
    bus_write(8'h62, 8'hFF); bus_read(8'h62, v);
    check(v == 8'h00, "R2 unmapped", 64'(v), 64'h0);
    bus_write(8'h60, 8'hD6); bus_read(8'h60, v);
    check(v == 8'hD6, "R2 ctrl readback", 64'(v), 64'hD6);
    check(spi_cs_n == 1'b1, "R3 no start without bit0", 64'(spi_cs_n), 64'd1);
    bus_write(8'h6C, 8'h00); bus_read(8'h6C, v);
    check(v == 8'h00, "R2 divider", 64'(v), 64'h0);
  endtask

  task automatic t_full_read();
    logic [7:0] cb, v;
    for (int i = 0; i < 8; i++) slave_bytes[i] = 8'h90 + 8'(i * 17);
    load_cmd(3'b010, 3, 3, 8'h9F, 8'h11, 8'h22, 8'h33, cb);
    bus_write(8'h60, cb | 8'h01);
    bus_read(8'h60, v);
    check(v == (cb | 8'h01), "R3 busy set", 64'(v), 64'(cb | 8'h01));
    poll_idle();
    bus_read(8'h60, v);
    check(v == cb, "R3 bit0 cleared, fields kept", 64'(v), 64'(cb));
    check_frame("full", 8'h9F, 8'h11, 8'h22, 8'h33, 3, 3);
    for (int j = 0; j < 3; j++) begin
      bus_read(8'h67 + 8'(j), v);
      check(v == slave_bytes[4 + j], "R5 response byte", 64'(v), 64'(slave_bytes[4 + j]));
    end
  endtask

  task automatic t_write_only();
    logic [7:0] cb, v;
    load_cmd(3'b011, 2, 0, 8'h01, 8'hE7, 8'h7E, 8'h00, cb);
    bus_write(8'h60, cb | 8'h01);
    poll_idle();
    check_frame("wr-only", 8'h01, 8'hE7, 8'h7E, 8'h00, 2, 0);
    for (int j = 0; j < 3; j++) begin
      bus_read(8'h67 + 8'(j), v);
      check(v == 8'h90 + 8'((4 + j) * 17), "R9 responses kept (rcnt 0)",
            64'(v), 64'(8'h90 + 8'((4 + j) * 17)));
    end
    bus_read(8'h60, v);
    check(v[7:5] == 3'b011, "R10 class readback", 64'(v[7:5]), 64'h3);
  endtask

  task automatic t_one_resp();
    logic [7:0] cb, v;
    for (int i = 0; i < 8; i++) slave_bytes[i] = 8'h0F ^ 8'(i * 29);
    load_cmd(3'b010, 0, 1, 8'h05, 8'hAA, 8'hBB, 8'hCC, cb);
    bus_write(8'h60, cb | 8'h01);
    poll_idle();
    check_frame("one-resp", 8'h05, 8'hAA, 8'hBB, 8'hCC, 0, 1);
    bus_read(8'h67, v);
    check(v == slave_bytes[1], "R5 single response", 64'(v), 64'(slave_bytes[1]));
    bus_read(8'h68, v);
    check(v == 8'h90 + 8'(5 * 17), "R9 second response kept", 64'(v), 64'(8'h90 + 8'(5 * 17)));
    bus_read(8'h69, v);
    check(v == 8'h90 + 8'(6 * 17), "R9 third response kept", 64'(v), 64'(8'h90 + 8'(6 * 17)));
  endtask

  task automatic t_erase_class();
    logic [7:0] cb;
    load_cmd(3'b101, 3, 0, 8'hD8, 8'h12, 8'h34, 8'h56, cb);
    bus_write(8'h60, cb | 8'h01);
    poll_idle();
    check_frame("R10 erase class", 8'hD8, 8'h12, 8'h34, 8'h56, 3, 0);
  endtask

  task automatic t_divider();
    logic [7:0] cb, v;
    bus_write(8'h6C, 8'h03);
    for (int i = 0; i < 8; i++) slave_bytes[i] = 8'hC0 + 8'(i);
    load_cmd(3'b010, 0, 1, 8'h4B, 8'h00, 8'h00, 8'h00, cb);
    bus_write(8'h60, cb | 8'h01);
    poll_idle();
    check((t_last - t_prev) == 40, "R7 SCK period div=3",
          64'(t_last - t_prev), 64'd40);
    check(spi_sck == 1'b0, "R7 SCK idle low", 64'(spi_sck), 64'd0);
    bus_read(8'h67, v);
    check(v == 8'hC1, "R5 response at slow clock", 64'(v), 64'hC1);
  endtask

  task automatic t_busy_write();
    logic [7:0] cb, v;
    bus_write(8'h6C, 8'h07);
    load_cmd(3'b010, 3, 3, 8'h0B, 8'h01, 8'h02, 8'h03, cb);
    bus_write(8'h60, cb | 8'h01);
    repeat (20) @(negedge clk);
    bus_write(8'h60, 8'h00);
    bus_read(8'h60, v);
    check(v == (cb | 8'h01), "R8 ctrl write ignored", 64'(v), 64'(cb | 8'h01));
    poll_idle();
    check_frame("R8 transfer intact", 8'h0B, 8'h01, 8'h02, 8'h03, 3, 3);
    check((t_last - t_prev) == 80, "R7 SCK period div=7",
          64'(t_last - t_prev), 64'd80);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) slave_bytes[i] = 8'h00;
    clr = 1'b1;
    repeat (3) @(negedge clk);
    clr = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regmap();
    t_full_read();
    t_write_only();
    t_one_resp();
    t_erase_class();
    t_divider();
    t_busy_write();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule